// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Logic Stage with Duplicated Completion Detection

This block is a clock-sampled, synthesizable model of one stage in a self-timed pipeline. Each data bit travels on two wires, a true rail and a false rail. The code 00 is the spacer (neutral), 01 is a valid 0, 10 is a valid 1 and 11 is illegal. The stage receives two N-bit dual-rail operands, A and B, on one input channel. It combines them bit by bit with AND, OR or XOR and places the result on an N-bit dual-rail output channel. Both channels use a four-phase return-to-zero handshake. The stage raises `in_ack` toward its sender and watches `out_ack` from its receiver.

Completion of the input channel and of the output channel is each sensed by two identical detector copies. A C-element merges the two copies. The C-element moves only when both copies ask for the same new level, so a broken copy freezes the handshake and does not let data through. Any disagreement between copies, and any 11 code, sets a sticky active-low alarm. The stage then enters a halt state and holds every output. Inputs `flt_in_chk` and `flt_out_chk` force the second copy of the input or output detector to report "neutral" permanently, which models a stuck detector. Stage alarms chain as an AND, `chip_alarm_n = alarm_n & alarm_up_n`.

The FSM has five states. IDLE moves to EVAL when the input is complete and `out_ack` is low, and loads the result. EVAL moves to OACK when the output is seen complete, and raises `in_ack`. OACK moves to DRAIN when `out_ack` is high, and returns the output to spacer. DRAIN moves to IDLE when both channels are seen neutral, and lowers `in_ack`. Any state moves to HALT on an alarm condition, and HALT is left only by reset.

Top module: `dr_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the stage afterwards shows `y_t`/`y_f` all 0 (spacer), `in_ack` low and `alarm_n` high, and its state is IDLE.
- R2: Each output bit i is the dual-rail code (`y_t[i]`,`y_f[i]`) = (r, ~r). Here r = a OP b, with a = `a_t[i]` and b = `b_t[i]`. `op_sel` 2'b00 selects AND, 2'b01 selects OR, 2'b10 selects XOR, and 2'b11 also selects AND. The output never carries the code 11.
- R3: With `out_ack` low, the output becomes valid exactly two clock edges after the edge at which the last input bit is first sampled valid.
- R4: `in_ack` rises exactly two edges after the output becomes valid, and never while the output is neutral.
- R5: In OACK, the output returns to spacer at the first edge that samples `out_ack` high.
- R6: `in_ack` stays high while any input bit is still valid. It falls within two edges once all input bits and all output bits are neutral.
- R7: No new result is loaded while `out_ack` is high. A waiting token is passed only after `out_ack` falls.
- R8: An input with both rails high on any bit drives `alarm_n` low one edge after it is sampled.
- R9: With `flt_in_chk` high, a valid input token raises the alarm, `in_ack` never rises and the output stays spacer.
- R10: With `flt_out_chk` high, the first result raises the alarm and `in_ack` never rises.
- R11: Once low, `alarm_n` stays low until reset, and `y_t`, `y_f` and `in_ack` hold their values.
- R12: `chip_alarm_n` equals `alarm_n & alarm_up_n` at all times.
- R13: A partly valid input, where some bits are still spacer, starts no computation and raises no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 2 | Per-bit function select, sampled when a result is loaded |
| a_t | input | N | Operand A, true rails |
| a_f | input | N | Operand A, false rails |
| b_t | input | N | Operand B, true rails |
| b_f | input | N | Operand B, false rails |
| in_ack | output | 1 | Acknowledge to the sender |
| y_t | output | N | Result, true rails |
| y_f | output | N | Result, false rails |
| out_ack | input | 1 | Acknowledge from the receiver |
| flt_in_chk | input | 1 | Forces input detector copy 2 stuck at neutral |
| flt_out_chk | input | 1 | Forces output detector copy 2 stuck at neutral |
| alarm_up_n | input | 1 | Alarm from upstream stages, active low |
| alarm_n | output | 1 | Sticky stage alarm, active low |
| chip_alarm_n | output | 1 | AND of stage and upstream alarms |

## Verification
The output becomes valid two edges after a complete input: one edge for the input C-element and one for the load. `in_ack` follows two edges later, through the output C-element. The spacer appears one edge after `out_ack` is seen, and an illegal code shows on `alarm_n` one edge after it is sampled. The directed bench drives inputs at falling edges and samples after a counted number of rising edges at exactly those offsets. The random token stream waits for each handshake level with a bounded poll, so handshake order is checked there and not exact latency. Fault and blocking cases are checked by holding the stimulus for several cycles and confirming that `in_ack`, the outputs and the alarm stayed where the requirements demand.

// File: rtl/dr_stage_pkg.sv
package dr_stage_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_XOR  = 2'b10,
        OP_AND2 = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVAL  = 3'd1,
        ST_OACK  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_HALT  = 3'd4
    } state_e;

    localparam int DETECT_COPIES = 2;

endpackage

// File: rtl/dr_rail_check.sv
// One copy of a dual-rail completion sensor over W bits.
module dr_rail_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] t,
    input  logic [W-1:0] f,
    input  logic         stuck,
    output logic         full,
    output logic         empty,
    output logic         illegal
);
    logic [W-1:0] bit_ok;
    logic [W-1:0] bit_bad;
    logic [W-1:0] bit_any;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i]  = t[i] ^ f[i];
        assign bit_bad[i] = t[i] & f[i];
        assign bit_any[i] = t[i] | f[i];
    end

    // A stuck copy keeps reporting a spacer whatever the wires carry.
    assign full    = stuck ? 1'b0 : (&bit_ok);
    assign empty   = stuck ? 1'b1 : ~(|bit_any);
    assign illegal = stuck ? 1'b0 : (|bit_bad);
endmodule

// File: rtl/dr_celem.sv
// Clocked two-input Muller C-element with disagreement flag.
module dr_celem (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q,
    output logic disagree
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (a == b) begin
            q <= a;
        end
    end

    assign disagree = a ^ b;
endmodule

// File: rtl/dr_dup_detect.sv
// Two sensor copies merged by a C-element.
module dr_dup_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] t,
    input  logic [W-1:0] f,
    input  logic         stuck_b,
    output logic         done,
    output logic         mismatch,
    output logic         illegal
);
    import dr_stage_pkg::*;

    logic [DETECT_COPIES-1:0] full_v;
    logic [DETECT_COPIES-1:0] empty_v;
    logic [DETECT_COPIES-1:0] ill_v;
    logic [DETECT_COPIES-1:0] req_v;

    for (genvar k = 0; k < DETECT_COPIES; k++) begin : g_copy
        dr_rail_check #(.W(W)) u_chk (
            .t       (t),
            .f       (f),
            .stuck   ((k == DETECT_COPIES - 1) ? stuck_b : 1'b0),
            .full    (full_v[k]),
            .empty   (empty_v[k]),
            .illegal (ill_v[k])
        );
        // Each copy asks for 1 when complete, 0 when spacer, else keeps.
        assign req_v[k] = full_v[k] ? 1'b1 : (empty_v[k] ? 1'b0 : done);
    end

    dr_celem u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .a        (req_v[0]),
        .b        (req_v[DETECT_COPIES-1]),
        .q        (done),
        .disagree (mismatch)
    );

    assign illegal = |ill_v;
endmodule

// File: rtl/dr_logic_unit.sv
// Bitwise function on two dual-rail words producing a dual-rail word.
module dr_logic_unit #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_t,
    input  logic [N-1:0] b_t,
    input  logic [1:0]   op,
    output logic [N-1:0] r_t,
    output logic [N-1:0] r_f
);
    import dr_stage_pkg::*;

    logic [N-1:0] res;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            unique case (op_e'(op))
                OP_OR:   res[i] = a_t[i] | b_t[i];
                OP_XOR:  res[i] = a_t[i] ^ b_t[i];
                OP_AND,
                OP_AND2: res[i] = a_t[i] & b_t[i];
                default: res[i] = a_t[i] & b_t[i];
            endcase
        end
    end

    assign r_t = res;
    assign r_f = ~res;
endmodule

// File: rtl/dr_stage.sv
module dr_stage #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_sel,
    input  logic [N-1:0] a_t,
    input  logic [N-1:0] a_f,
    input  logic [N-1:0] b_t,
    input  logic [N-1:0] b_f,
    output logic         in_ack,
    output logic [N-1:0] y_t,
    output logic [N-1:0] y_f,
    input  logic         out_ack,
    input  logic         flt_in_chk,
    input  logic         flt_out_chk,
    input  logic         alarm_up_n,
    output logic         alarm_n,
    output logic         chip_alarm_n
);
    import dr_stage_pkg::*;

    localparam int IW = 2 * N;

    state_e       state, state_nx;
    logic         in_done, in_mis, in_ill;
    logic         out_done, out_mis, out_ill;
    logic         alarm_hit, alarm_q;
    logic [N-1:0] r_t, r_f;

    dr_dup_detect #(.W(IW)) u_in_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .t        ({a_t, b_t}),
        .f        ({a_f, b_f}),
        .stuck_b  (flt_in_chk),
        .done     (in_done),
        .mismatch (in_mis),
        .illegal  (in_ill)
    );

    dr_dup_detect #(.W(N)) u_out_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .t        (y_t),
        .f        (y_f),
        .stuck_b  (flt_out_chk),
        .done     (out_done),
        .mismatch (out_mis),
        .illegal  (out_ill)
    );

    dr_logic_unit #(.N(N)) u_fn (
        .a_t (a_t),
        .b_t (b_t),
        .op  (op_sel),
        .r_t (r_t),
        .r_f (r_f)
    );

    assign alarm_hit = in_mis | in_ill | out_mis | out_ill;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_done && !out_ack)   state_nx = ST_EVAL;
            ST_EVAL:  if (out_done)              state_nx = ST_OACK;
            ST_OACK:  if (out_ack)               state_nx = ST_DRAIN;
            ST_DRAIN: if (!in_done && !out_done) state_nx = ST_IDLE;
            ST_HALT:                             state_nx = ST_HALT;
            default:                             state_nx = ST_HALT;
        endcase
        if (alarm_hit) begin
            state_nx = ST_HALT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_t     <= '0;
            y_f     <= '0;
            in_ack  <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            alarm_q <= alarm_q | alarm_hit;
            if (!alarm_hit) begin
                unique case (state)
                    ST_IDLE: if (in_done && !out_ack) begin
                        y_t <= r_t;
                        y_f <= r_f;
                    end
                    ST_EVAL: if (out_done) begin
                        in_ack <= 1'b1;
                    end
                    ST_OACK: if (out_ack) begin
                        y_t <= '0;
                        y_f <= '0;
                    end
                    ST_DRAIN: if (!in_done && !out_done) begin
                        in_ack <= 1'b0;
                    end
                    ST_HALT: ;
                    default: ;
                endcase
            end
        end
    end

    assign alarm_n      = ~alarm_q;
    assign chip_alarm_n = alarm_n & alarm_up_n;
endmodule

// File: rtl/dr_stage_chk.sv
module dr_stage_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a_t,
    input logic [N-1:0] a_f,
    input logic [N-1:0] b_t,
    input logic [N-1:0] b_f,
    input logic         in_ack,
    input logic [N-1:0] y_t,
    input logic [N-1:0] y_f,
    input logic         out_ack,
    input logic         alarm_up_n,
    input logic         alarm_n,
    input logic         chip_alarm_n
);
    p_reset_spacer_r1: assert property (@(posedge clk)
        !rst_n |=> (y_t == '0 && y_f == '0 && !in_ack && alarm_n));

    p_no_illegal_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (y_t & y_f) == '0);

    p_ack_after_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> ((y_t ^ y_f) == {N{1'b1}}));

    p_ack_fall_spacer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> ($past(a_t | a_f | b_t | b_f) == '0));

    p_load_waits_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(y_t | y_f) == '0) && ((y_t | y_f) != '0)) |-> !$past(out_ack));

    p_alarm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n |=> !alarm_n);

    p_halt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n |=> ($stable(y_t) && $stable(y_f) && $stable(in_ack)));

    always_comb begin
        p_chip_and_r12: assert (chip_alarm_n == (alarm_n & alarm_up_n));
    end
endmodule

bind dr_stage dr_stage_chk #(.N(N)) u_dr_stage_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_t          (a_t),
    .a_f          (a_f),
    .b_t          (b_t),
    .b_f          (b_f),
    .in_ack       (in_ack),
    .y_t          (y_t),
    .y_f          (y_f),
    .out_ack      (out_ack),
    .alarm_up_n   (alarm_up_n),
    .alarm_n      (alarm_n),
    .chip_alarm_n (chip_alarm_n)
);

// File: tb/tb_dr_stage.sv
module tb_dr_stage;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   op_sel;
    logic [N-1:0] a_t, a_f, b_t, b_f;
    logic         in_ack;
    logic [N-1:0] y_t, y_f;
    logic         out_ack;
    logic         flt_in_chk, flt_out_chk;
    logic         alarm_up_n;
    logic         alarm_n, chip_alarm_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dr_stage #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .in_ack(in_ack), .y_t(y_t), .y_f(y_f), .out_ack(out_ack),
        .flt_in_chk(flt_in_chk), .flt_out_chk(flt_out_chk),
        .alarm_up_n(alarm_up_n), .alarm_n(alarm_n), .chip_alarm_n(chip_alarm_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model(input logic [1:0] op, input logic [N-1:0] a, input logic [N-1:0] b);
        case (op)
            2'b01:   return a | b;
            2'b10:   return a ^ b;
            default: return a & b;
        endcase
    endfunction

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_a(input logic [N-1:0] v);
        a_t = v; a_f = ~v;
    endtask

    task automatic put_b(input logic [N-1:0] v);
        b_t = v; b_f = ~v;
    endtask

    task automatic spacer_in();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; out_ack = 1'b0; flt_in_chk = 1'b0; flt_out_chk = 1'b0;
        alarm_up_n = 1'b1; op_sel = 2'b00;
        spacer_in();
        adv(3);
        rst_n = 1'b1;
        adv(1);
    endtask

    task automatic run_token(input logic [N-1:0] a, input logic [N-1:0] b, input logic [1:0] op);
        int n;
        logic [N-1:0] e;
        e = model(op, a, b);
        op_sel = op; put_a(a); put_b(b);
        n = 0;
        while (((y_t ^ y_f) != {N{1'b1}}) && n < 40) begin adv(1); n++; end
        chk(y_t == e && y_f == ~e, "R2 result", {24'd0, y_t}, {24'd0, e});
        while (!in_ack && n < 40) begin adv(1); n++; end
        chk(in_ack == 1'b1, "R4 ack raised", {31'd0, in_ack}, 32'd1);
        spacer_in();
        out_ack = 1'b1;
        n = 0;
        while ((((y_t | y_f) != '0) || in_ack) && n < 40) begin adv(1); n++; end
        chk((y_t | y_f) == '0 && !in_ack, "R6 return to spacer", {31'd0, in_ack}, 32'd0);
        out_ack = 1'b0;
        adv(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(y_t == '0 && y_f == '0, "R1 output spacer", {24'd0, y_t | y_f}, 32'd0);
        chk(!in_ack && alarm_n, "R1 ack low alarm clear", {30'd0, in_ack, alarm_n}, 32'd1);

        // R3/R4/R5 exact timing
        op_sel = 2'b10; put_a(8'hA5); put_b(8'h0F);
        adv(1);
        chk((y_t | y_f) == '0, "R3 not yet valid after one edge", {24'd0, y_t | y_f}, 32'd0);
        adv(1);
        chk(y_t == 8'hAA && y_f == 8'h55, "R3 valid after two edges", {24'd0, y_t}, 32'hAA);
        adv(1);
        chk(!in_ack, "R4 ack still low one edge after valid", {31'd0, in_ack}, 32'd0);
        adv(1);
        chk(in_ack, "R4 ack high two edges after valid", {31'd0, in_ack}, 32'd1);
        out_ack = 1'b1;
        adv(1);
        chk((y_t | y_f) == '0, "R5 spacer one edge after out_ack", {24'd0, y_t | y_f}, 32'd0);

        // R6 partial spacer holds ack
        a_t = '0; a_f = '0;
        adv(6);
        chk(in_ack, "R6 ack held while B still valid", {31'd0, in_ack}, 32'd1);
        b_t = '0; b_f = '0;
        adv(2);
        chk(!in_ack, "R6 ack falls after full spacer", {31'd0, in_ack}, 32'd0);

        // R7 no load while out_ack high
        op_sel = 2'b01; put_a(8'h30); put_b(8'h03);
        adv(6);
        chk((y_t | y_f) == '0, "R7 held while out_ack high", {24'd0, y_t | y_f}, 32'd0);
        out_ack = 1'b0;
        adv(2);
        chk(y_t == 8'h33 && y_f == 8'hCC, "R7 passes after out_ack falls", {24'd0, y_t}, 32'h33);
        adv(2);
        spacer_in(); out_ack = 1'b1;
        adv(4);
        out_ack = 1'b0;
        adv(1);

        // R13 partial valid input
        put_a(8'hFF); b_t = '0; b_f = '0; op_sel = 2'b00;
        adv(6);
        chk((y_t | y_f) == '0 && !in_ack, "R13 partial input ignored", {24'd0, y_t | y_f}, 32'd0);
        put_b(8'h5A);
        adv(2);
        chk(y_t == 8'h5A, "R13 proceeds when complete", {24'd0, y_t}, 32'h5A);
        adv(2);
        spacer_in(); out_ack = 1'b1;
        adv(4);
        out_ack = 1'b0;
        adv(1);

        // R2 directed: reserved op code and extreme words
        run_token(8'hC3, 8'hF0, 2'b11);
        run_token(8'h00, 8'hFF, 2'b10);
        run_token(8'hFF, 8'hFF, 2'b00);

        // R2 random stream
        for (int k = 0; k < 40; k++) begin
            run_token(8'($urandom), 8'($urandom), 2'($urandom));
        end
        chk(alarm_n, "R11 no alarm in clean run", {31'd0, alarm_n}, 32'd1);

        // R12 chain
        alarm_up_n = 1'b0;
        #1;
        chk(!chip_alarm_n, "R12 upstream alarm passes", {31'd0, chip_alarm_n}, 32'd0);
        alarm_up_n = 1'b1;
        #1;
        chk(chip_alarm_n, "R12 clear when both clear", {31'd0, chip_alarm_n}, 32'd1);
        adv(1);

        // R8 illegal input code
        do_reset();
        a_t = 8'h01; a_f = 8'h01;
        adv(1);
        chk(!alarm_n, "R8 alarm one edge after 11 code", {31'd0, alarm_n}, 32'd0);
        chk(!chip_alarm_n, "R12 stage alarm reaches chip", {31'd0, chip_alarm_n}, 32'd0);
        spacer_in();
        adv(5);
        chk(!alarm_n, "R11 alarm sticky", {31'd0, alarm_n}, 32'd0);
        put_a(8'h11); put_b(8'h11);
        adv(6);
        chk((y_t | y_f) == '0 && !in_ack, "R11 halted stage ignores tokens", {24'd0, y_t | y_f}, 32'd0);

        // R9 input checker fault
        do_reset();
        chk(alarm_n, "R1 reset clears alarm", {31'd0, alarm_n}, 32'd1);
        flt_in_chk = 1'b1;
        put_a(8'h0F); put_b(8'hF0); op_sel = 2'b01;
        adv(8);
        chk(!alarm_n, "R9 alarm on input checker fault", {31'd0, alarm_n}, 32'd0);
        chk(!in_ack && (y_t | y_f) == '0, "R9 stall no ack no data", {31'd0, in_ack}, 32'd0);

        // R10 output checker fault
        do_reset();
        flt_out_chk = 1'b1;
        put_a(8'h0F); put_b(8'hF0); op_sel = 2'b01;
        adv(10);
        chk(!alarm_n, "R10 alarm on output checker fault", {31'd0, alarm_n}, 32'd0);
        chk(!in_ack, "R10 ack never rises", {31'd0, in_ack}, 32'd0);
        chk(y_t == 8'hFF, "R11 output frozen after alarm", {24'd0, y_t}, 32'hFF);
        spacer_in(); out_ack = 1'b1;
        adv(5);
        chk(y_t == 8'hFF && !in_ack && !alarm_n, "R11 frozen despite out_ack", {24'd0, y_t}, 32'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule